// File: doc/BRIEF.md
# I2C Start and Acknowledge Controller

This block is the slice of an I2C bus interface that produces start conditions and acknowledge bits. Software writes one control word. The word carries an interface enable, a start request, a stop request, a bus-release command and an acknowledge enable. From these the block drives the open-drain pull-down enables for SCL and SDA.

If software requests a start while the bus is free, the block pulls SDA low. It keeps SCL released for a programmable hold time and only then hands the bus over with SCL held low. If the bus is busy, the request is kept and issued as soon as the bus frees. If the device is master and is stalling the bus in a wait, the request turns into a repeated start. The block emits one-cycle pulses on completion of a start and on arbitration loss.

Bus activity is tracked by watching the lines. A start seen on the bus marks it busy. A stop seen on the bus marks it free. The bus is also taken as free once both lines have stayed high for the hold count while the block is idle. The acknowledge driver pulls SDA low during the ninth clock of a received byte. It is suppressed on address bytes unless the extension-code flag is present.

Top module: `i2c_start_ack_ctrl`

## Requirements
- R1: During and right after reset, scl_oe, sda_oe, start_pending, ack_enabled, start_done and arb_lost are 0 and bus_busy is 1.
- R2: While enabled and idle, bus_busy falls on the (hold_cycles+1)-th clock edge after the enabling write, provided both lines stay high. A start seen on the bus (SDA falling while SCL is high) sets bus_busy at the next edge. A stop seen on the bus (SDA rising while SCL is high) clears it at the next edge.
- R3: Take a legal start write (enable=1, start=1, stop=0, release=0) made on a free bus while idle. One edge after the write, sda_oe rises while scl_oe stays 0.
- R4: sda_oe stays high with scl_oe low for hold_cycles+1 cycles. At the next edge start_done pulses for one cycle, sda_oe is released and scl_oe takes the value of master_wait.
- R5: A start written while bus_busy is 1 produces no bus activity and is held pending. sda_oe rises one edge after bus_busy falls.
- R6: A start written while master with master_wait=1 first gives hold_cycles+1 cycles of SCL held low with SDA released. It then gives hold_cycles+1 cycles with both released and SCL high. It then proceeds as in R3 and R4.
- R7: If SDA is seen low while SCL is high during the both-released phase of R6, arb_lost pulses for one cycle and the pending start is cleared. Both lines are released.
- R8: The pending start is cleared by completion (R4), by arbitration loss, by a write with release=1, by a write with enable=0, and by a write with start=0. A cleared reservation never reaches the bus.
- R9: A write with start=1 and stop=1 together does not set the start request and produces no bus activity.
- R10: start_pending reads 0 in the cycle right after any control write. Otherwise it shows the held start request.
- R11: While enabled and idle or master, sda_oe equals ack_enable AND ack_slot AND (NOT addr_byte OR ext_code).
- R12: ack_enabled changes only on a control write, where it takes the written value; disabling does not clear it. While enable is 0, a start write has no effect and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_enable | input | 1 | Written interface enable |
| cfg_start | input | 1 | Written start request |
| cfg_stop | input | 1 | Written stop request |
| cfg_release | input | 1 | Written bus-release command |
| cfg_ack_en | input | 1 | Written acknowledge enable |
| hold_cycles | input | CW | Start hold time and bus-free count, in clocks |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| master_wait | input | 1 | Device is master and stalling the bus |
| ack_slot | input | 1 | Ninth clock period of a received byte |
| addr_byte | input | 1 | Current byte is an address byte |
| ext_code | input | 1 | Extension code received |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| start_pending | output | 1 | Start request readback |
| ack_enabled | output | 1 | Acknowledge enable readback |
| bus_busy | output | 1 | Bus in use |
| start_done | output | 1 | One-cycle pulse when a start is complete |
| arb_lost | output | 1 | One-cycle pulse on arbitration loss |

## Verification
A wrong sequencer state shows at once on the pull-down enables. The bench compares sda_oe, scl_oe and start_done on every cycle of each start and repeated start against a cycle-indexed expectation. An off-by-one hold count or a skipped phase therefore shows in the first cycle it happens. A corrupted bus-busy flag shows either as a start that launches while another master holds SDA low, or as a reservation that fails to launch on the edge after a stop. A start request that is not cleared shows as an unexpected SDA pull-down after a release, disable or zero write, within a few cycles of the next bus-free event.

// File: rtl/i2c_start_ack_ctrl.sv
module i2c_start_ack_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_enable,
  input  logic          cfg_start,
  input  logic          cfg_stop,
  input  logic          cfg_release,
  input  logic          cfg_ack_en,
  input  logic [CW-1:0] hold_cycles,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          master_wait,
  input  logic          ack_slot,
  input  logic          addr_byte,
  input  logic          ext_code,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          start_pending,
  output logic          ack_enabled,
  output logic          bus_busy,
  output logic          start_done,
  output logic          arb_lost
);

  typedef enum logic [2:0] {S_IDLE, S_GEN, S_MST, S_RS_LOW, S_RS_HIGH} st_t;

  st_t           st;
  logic          en_q, ack_q, start_q, wr_seen, busy_q, scl_d, sda_d;
  logic [CW-1:0] tmr, free_cnt;

  logic start_seen, stop_seen, tmr_hit, ack_drive;
  logic force_idle, kill, launch, restart, arb_hit, gen_done;

  assign start_seen = scl_in & scl_d & sda_d & ~sda_in;
  assign stop_seen  = scl_in & scl_d & ~sda_d & sda_in;
  assign tmr_hit    = (tmr == hold_cycles);
  assign ack_drive  = en_q & ack_q & ack_slot & (~addr_byte | ext_code);

  assign force_idle = cfg_wr & (~cfg_enable | cfg_release);
  assign kill       = cfg_wr & (~cfg_enable | cfg_release | ~cfg_start);
  assign launch     = en_q & start_q & (st == S_IDLE) & ~busy_q & ~kill;
  assign restart    = en_q & start_q & (st == S_MST) & master_wait & ~kill;
  assign arb_hit    = (st == S_RS_HIGH) & scl_in & ~sda_in;
  assign gen_done   = (st == S_GEN) & tmr_hit;

  assign sda_oe = (st == S_GEN) |
                  (((st == S_IDLE) | (st == S_MST)) & ack_drive);
  assign scl_oe = (st == S_RS_LOW) | ((st == S_MST) & master_wait);

  assign start_pending = start_q & ~wr_seen;
  assign ack_enabled   = ack_q;
  assign bus_busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ack_q   <= 1'b0;
      wr_seen <= 1'b0;
    end else begin
      wr_seen <= cfg_wr;
      if (cfg_wr) begin
        en_q  <= cfg_enable;
        ack_q <= cfg_ack_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      start_q <= 1'b0;
    else if (cfg_wr) begin
      if (!cfg_enable || cfg_release || !cfg_start) start_q <= 1'b0;
      else if (!cfg_stop)                          start_q <= 1'b1;
      else                                         start_q <= start_q & ~(gen_done | arb_hit);
    end else if (!en_q || gen_done || arb_hit)
      start_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tmr        <= '0;
      start_done <= 1'b0;
      arb_lost   <= 1'b0;
    end else begin
      start_done <= gen_done & ~force_idle;
      arb_lost   <= arb_hit & ~force_idle;
      if (force_idle) begin
        st  <= S_IDLE;
        tmr <= '0;
      end else begin
        case (st)
          S_IDLE: if (launch) begin
            st  <= S_GEN;
            tmr <= '0;
          end
          S_GEN: begin
            if (tmr_hit) st  <= S_MST;
            else         tmr <= tmr + CW'(1);
          end
          S_MST: if (restart) begin
            st  <= S_RS_LOW;
            tmr <= '0;
          end
          S_RS_LOW: begin
            if (tmr_hit) begin
              st  <= S_RS_HIGH;
              tmr <= '0;
            end else tmr <= tmr + CW'(1);
          end
          S_RS_HIGH: begin
            if (arb_hit)      st  <= S_IDLE;
            else if (!scl_in) tmr <= '0;
            else if (tmr_hit) begin
              st  <= S_GEN;
              tmr <= '0;
            end else tmr <= tmr + CW'(1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b1;
      free_cnt <= '0;
    end else if (!en_q) begin
      busy_q   <= 1'b1;
      free_cnt <= '0;
    end else if (start_seen) begin
      busy_q   <= 1'b1;
      free_cnt <= '0;
    end else if (stop_seen) begin
      busy_q   <= 1'b0;
      free_cnt <= '0;
    end else if (st != S_IDLE || !(scl_in && sda_in)) begin
      free_cnt <= '0;
    end else if (free_cnt == hold_cycles) begin
      busy_q <= 1'b0;
    end else begin
      free_cnt <= free_cnt + CW'(1);
    end
  end

endmodule

// File: rtl/i2c_start_ack_ctrl_chk.sv
module i2c_start_ack_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic cfg_start,
  input logic cfg_stop,
  input logic sda_oe,
  input logic scl_oe,
  input logic start_done,
  input logic arb_lost,
  input logic en_q,
  input logic start_q,
  input logic ack_q
);

  // R4
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |-> $past(sda_oe) && !$past(scl_oe));

  // R12
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !sda_oe && !scl_oe);

  // R9
  illegal_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_start && cfg_stop && !start_q) |=> !start_q);

  // R8
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_done && !$past(cfg_wr)) |-> !start_q);

  // R7
  arb_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !$past(cfg_wr)) |-> !start_q);

  // R12
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(ack_q));

endmodule

bind i2c_start_ack_ctrl i2c_start_ack_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_start  (cfg_start),
  .cfg_stop   (cfg_stop),
  .sda_oe     (sda_oe),
  .scl_oe     (scl_oe),
  .start_done (start_done),
  .arb_lost   (arb_lost),
  .en_q       (en_q),
  .start_q    (start_q),
  .ack_q      (ack_q)
);

// File: tb/i2c_start_ack_ctrl_bench.sv
module i2c_start_ack_ctrl_bench;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_start = 1'b0, cfg_stop = 1'b0;
  logic cfg_release = 1'b0, cfg_ack_en = 1'b0;
  logic [CW-1:0] hold_cycles = 8'd3;
  logic master_wait = 1'b0, ack_slot = 1'b0, addr_byte = 1'b0, ext_code = 1'b0;
  logic ext_scl = 1'b0, ext_sda = 1'b0;
  logic scl_in, sda_in, scl_oe, sda_oe, start_pending, ack_enabled;
  logic bus_busy, start_done, arb_lost;

  int nvec = 0;
  int nfail = 0;

  assign scl_in = ~(scl_oe | ext_scl);
  assign sda_in = ~(sda_oe | ext_sda);

  always #5 clk = ~clk;

  i2c_start_ack_ctrl #(.CW(CW)) u_i2c_start_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
    .cfg_start(cfg_start), .cfg_stop(cfg_stop), .cfg_release(cfg_release),
    .cfg_ack_en(cfg_ack_en), .hold_cycles(hold_cycles), .scl_in(scl_in),
    .sda_in(sda_in), .master_wait(master_wait), .ack_slot(ack_slot),
    .addr_byte(addr_byte), .ext_code(ext_code), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .start_pending(start_pending), .ack_enabled(ack_enabled),
    .bus_busy(bus_busy), .start_done(start_done), .arb_lost(arb_lost));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit st, input bit sp, input bit rel, input bit ack);
    cfg_enable = en; cfg_start = st; cfg_stop = sp; cfg_release = rel; cfg_ack_en = ack;
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0; cfg_start = 1'b0; cfg_stop = 1'b0; cfg_release = 1'b0;
  endtask

  // expected {sda_oe, scl_oe, start_done} k cycles after a start is launched
  function automatic int gen_exp(int k, int h);
    if (k <= h + 1) return 3'b100;
    return 3'b011;
  endfunction

  function automatic int seq_exp(int k, int h, bit rs);
    if (!rs) return gen_exp(k, h);
    if (k <= h + 1) return 3'b010;
    if (k <= 2 * h + 2) return 3'b000;
    return gen_exp(k - (2 * h + 2), h);
  endfunction

  task automatic run_seq(input string tag, input int h, input bit rs);
    int total = rs ? (3 * h + 4) : (h + 2);
    for (int k = 1; k <= total; k++) begin
      tick();
      chk(tag, {sda_oe, scl_oe, start_done}, seq_exp(k, h, rs));
    end
  endtask

  task automatic quiet(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      tick();
      chk(tag, {sda_oe, scl_oe}, 0);
    end
  endtask

  task automatic go_free(input int h);
    wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < h + 1; k++) tick();
    chk("R2 bus free after idle count", bus_busy, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    int h;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    master_wait = 1'b1;
    tick(); tick();
    chk("R1 reset outputs", {scl_oe, sda_oe, start_pending, ack_enabled, start_done, arb_lost}, 0);
    chk("R1 reset busy", bus_busy, 1);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset outputs", {scl_oe, sda_oe, start_pending, ack_enabled, start_done, arb_lost}, 0);

    // R2 exact free timing, hold 3
    hold_cycles = 8'd3;
    wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) tick();
    chk("R2 still busy before count", bus_busy, 1);
    tick();
    chk("R2 free at count", bus_busy, 0);

    // R11 / R12 acknowledge driving, SCL held low by another device
    ext_scl = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    ack_slot = 1'b1; addr_byte = 1'b0; ext_code = 1'b0; #1;
    chk("R11 ack on data byte", sda_oe, 1);
    addr_byte = 1'b1; #1;
    chk("R11 ack suppressed on address", sda_oe, 0);
    ext_code = 1'b1; #1;
    chk("R11 ack on address with ext code", sda_oe, 1);
    ack_slot = 1'b0; #1;
    chk("R11 no ack outside ninth clock", sda_oe, 0);
    repeat (5) tick();
    chk("R12 ack enable holds without write", ack_enabled, 1);
    wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    ack_slot = 1'b1; addr_byte = 1'b0; #1;
    chk("R12 ack kept while disabled", ack_enabled, 1);
    chk("R12 no ack drive while disabled", sda_oe, 0);
    wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b1); #1;
    chk("R12 ack active again after enable", sda_oe, 1);
    wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0); #1;
    chk("R12 ack cleared by write", {ack_enabled, sda_oe}, 0);
    ack_slot = 1'b0; ext_code = 1'b0; addr_byte = 1'b0; ext_scl = 1'b0;

    // R12 start ignored while disabled
    wr(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    quiet("R12 start ignored while disabled", 4);
    chk("R12 no pending while disabled", start_pending, 0);
    go_free(3);

    // R9 illegal start + stop
    wr(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    quiet("R9 start with stop ignored", 4);
    chk("R9 no pending after illegal pair", start_pending, 0);

    // R3 R4 start, then R6 restart, then R7 arbitration loss
    h = 3;
    wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10 readback zero after write", start_pending, 0);
    run_seq("R3/R4 idle start", h, 1'b0);
    chk("R8 cleared after start", start_pending, 0);
    wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_seq("R6 restart from wait", h, 1'b1);
    wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    ext_sda = 1'b1;
    for (int k = 0; k < h + 2; k++) tick();
    chk("R7 no loss before SCL high phase", arb_lost, 0);
    tick();
    chk("R7 arbitration lost pulse", arb_lost, 1);
    chk("R7 start cleared and lines released", {start_pending, sda_oe, scl_oe}, 0);
    tick();
    chk("R7 pulse one cycle", arb_lost, 0);
    ext_sda = 1'b0;

    // R8 clears of a reservation: release, zero write, disable
    for (int m = 0; m < 3; m++) begin
      go_free(3);
      ext_sda = 1'b1;
      tick();
      chk("R2 start seen sets busy", bus_busy, 1);
      wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      tick();
      chk("R5 reservation pending", start_pending, 1);
      if (m == 0) wr(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      else if (m == 1) wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      else begin
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      end
      tick();
      chk("R8 reservation cleared", start_pending, 0);
      ext_sda = 1'b0;
      quiet("R8 cleared reservation stays off bus", 8);
    end

    // constrained random mix of idle start, reservation and restart
    for (int it = 0; it < 40; it++) begin
      int mode;
      h = int'($urandom % 5);
      mode = int'($urandom % 3);
      wr(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      hold_cycles = CW'(h);
      go_free(h);
      if (mode == 1) begin
        ext_sda = 1'b1;
        tick();
        chk("R2 external start busy", bus_busy, 1);
        wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 readback zero after write", start_pending, 0);
        for (int k = 0; k < 1 + int'($urandom % 4); k++) begin
          tick();
          chk("R5 held while busy", {sda_oe, start_pending}, 1);
        end
        ext_sda = 1'b0;
        tick();
        chk("R2 stop seen frees bus", {bus_busy, sda_oe}, 0);
        run_seq("R5 reservation launch", h, 1'b0);
      end else begin
        wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 readback zero after write", start_pending, 0);
        run_seq("R3/R4 random idle start", h, 1'b0);
        if (mode == 2) begin
          wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
          run_seq("R6 random restart", h, 1'b1);
        end
      end
      chk("R8 start cleared after completion", start_pending, 0);
    end

    summary();
  end
endmodule